// File: doc/BRIEF.md
# Bus-Fed Accumulator ALU with Flags

This block is the integer arithmetic core of a small processor whose registers share one data bus. A sequencer performs a two-operand operation in two steps. It first places the first operand on the bus and pulses the operand-hold strobe, which copies the bus into an internal holding register (TMP). It then places the second operand on the bus, sets the opcode, and pulses the result strobe, the flag strobe, or both. The result is stored in an accumulator (ACC). The ACC value is an output, so the sequencer can drive it back onto the bus as the operand of a later step.

Single-operand operations (increment, decrement, invert, shifts, negate and pass-through) take their operand straight from the bus and ignore TMP. A three-bit flag register holds a carry, an equality flag and a first-operand-larger flag. Add and both shifts read the stored carry and also write it, so the sequencer can chain words wider than one byte across several steps. Compare writes only the equality and larger flags and never changes ACC.

Top module: `acc_alu`

## Requirements
- R1: On a synchronous active-high reset, TMP, ACC, carry, equal and above all become 0.
- R2: When `hold_we_i` is high at a clock edge, TMP takes the bus value; otherwise TMP keeps its value. An operation performed in the same cycle as a TMP load uses the old TMP value.
- R3: Opcode 0 (add): the result is TMP + bus + carry. When flags are written, carry becomes the carry out of the top bit.
- R4: Opcode 1 (subtract): the result is TMP + ~bus + 1, which is TMP minus bus. When flags are written, carry becomes 1 when TMP >= bus (no borrow) and 0 otherwise.
- R5: Opcodes 2 (increment), 3 (decrement) and 10 (negate) give bus+1, bus-1 and the two's complement of the bus, each modulo 2^WIDTH. They leave carry unchanged.
- R6: Opcodes 4, 5 and 6 give TMP AND, OR and XOR bus. Opcode 7 gives the bitwise inverse of the bus. None of them changes carry.
- R7: Opcode 8 (shift left) gives {bus[W-2:0], carry}. Opcode 9 (shift right) gives {carry, bus[W-1:1]}. When flags are written, carry takes the bit shifted out: bus[W-1] for a left shift, bus[0] for a right shift.
- R8: Opcode 11 (compare), with flags written, sets equal to (TMP == bus) and above to (TMP > bus), both unsigned. When both are 0, the bus operand is the larger. Compare never changes ACC or carry, even when `res_we_i` is high.
- R9: The equal and above flags change only on a compare with `flag_we_i` high. They are never both 1.
- R10: Opcodes 12 to 15 copy the bus into ACC and leave all flags unchanged.
- R11: ACC changes only when `res_we_i` is high, and the flags change only when `flag_we_i` is high. The two strobes act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_i | input | WIDTH | Shared data bus value (second or only operand) |
| op_i | input | OP_W | Operation code |
| hold_we_i | input | 1 | Capture the bus into TMP |
| res_we_i | input | 1 | Store the selected result into ACC |
| flag_we_i | input | 1 | Update the flags the operation owns |
| acc_o | output | WIDTH | Accumulator value |
| carry_o | output | 1 | Stored carry |
| equal_o | output | 1 | Operands were equal at the last compare |
| above_o | output | 1 | TMP was larger at the last compare |

## Verification
The bench chains adds whose carry-in comes from the previous step, including one case where the carry-in alone causes the wrap. A design that ignored the stored carry would produce a result one too low. Shifts are run back to back so that each shifted-out bit must return as the next shifted-in bit; wiring the carry into the wrong end would garble the chain. Subtract is driven with equal operands and with a borrow, which exposes an inverted borrow sense. Compare is tried in all three orderings while the result strobe is high, to catch a compare that overwrites ACC or swaps the flag meanings. Strobe-off steps, a TMP load in the same cycle as an add, and pass-through opcodes show whether ACC, TMP or the flags move when they must stay.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD = 4'd0,
      OPC_SUB = 4'd1,
      OPC_INC = 4'd2,
      OPC_DEC = 4'd3,
      OPC_AND = 4'd4,
      OPC_OR  = 4'd5,
      OPC_XOR = 4'd6,
      OPC_NOT = 4'd7,
      OPC_SHL = 4'd8,
      OPC_SHR = 4'd9,
      OPC_NEG = 4'd10,
      OPC_CMP = 4'd11
   } opc_e;

   typedef struct packed {
      logic carry;
      logic equal;
      logic above;
   } flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] add_o,
   output logic         add_c_o,
   output logic [W-1:0] sub_o,
   output logic         sub_c_o,
   output logic [W-1:0] inc_o,
   output logic [W-1:0] dec_o,
   output logic [W-1:0] neg_o
);
   localparam int SW = W + 1;

   logic [SW-1:0] add_s;
   logic [SW-1:0] sub_s;

   assign add_s = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
   assign sub_s = {1'b0, a_i} + {1'b0, ~b_i} + SW'(1);

   assign add_o   = add_s[W-1:0];
   assign add_c_o = add_s[W];
   assign sub_o   = sub_s[W-1:0];
   assign sub_c_o = sub_s[W];
   assign inc_o   = b_i + W'(1);
   assign dec_o   = b_i - W'(1);
   assign neg_o   = (~b_i) + W'(1);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] and_o,
   output logic [W-1:0] or_o,
   output logic [W-1:0] xor_o,
   output logic [W-1:0] inv_o
);
   assign and_o = a_i & b_i;
   assign or_o  = a_i | b_i;
   assign xor_o = a_i ^ b_i;
   assign inv_o = ~b_i;
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] shl_o,
   output logic         shl_c_o,
   output logic [W-1:0] shr_o,
   output logic         shr_c_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lo
         assign shl_o[i] = cin_i;
      end else begin : g_lo_n
         assign shl_o[i] = b_i[i-1];
      end
      if (i == W - 1) begin : g_hi
         assign shr_o[i] = cin_i;
      end else begin : g_hi_n
         assign shr_o[i] = b_i[i+1];
      end
   end

   assign shl_c_o = b_i[W-1];
   assign shr_c_o = b_i[0];
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int W        = 8,
   parameter bit FROM_SUB = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         equal_o,
   output logic         above_o
);
   assign equal_o = (a_i == b_i);

   if (FROM_SUB) begin : g_sub
      logic [W:0] diff;
      assign diff    = {1'b0, a_i} - {1'b0, b_i};
      assign above_o = ~diff[W] & ~equal_o;
   end else begin : g_mag
      assign above_o = (a_i > b_i);
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter int OP_W         = 4,
   parameter bit CMP_FROM_SUB = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] bus_i,
   input  logic [OP_W-1:0]  op_i,
   input  logic             hold_we_i,
   input  logic             res_we_i,
   input  logic             flag_we_i,
   output logic [WIDTH-1:0] acc_o,
   output logic             carry_o,
   output logic             equal_o,
   output logic             above_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("acc_alu: WIDTH must be at least 2");
   end
   if (OP_W < OPC_W) begin : g_bad_opw
      $error("acc_alu: OP_W must cover the 4-bit operation field");
   end

   logic [WIDTH-1:0] tmp_q;
   logic [WIDTH-1:0] acc_q;
   flags_t           flags_q;

   logic [OPC_W-1:0] opc;
   logic             ext_zero;

   assign opc = op_i[OPC_W-1:0];
   if (OP_W > OPC_W) begin : g_ext
      assign ext_zero = ~|op_i[OP_W-1:OPC_W];
   end else begin : g_noext
      assign ext_zero = 1'b1;
   end

   logic [WIDTH-1:0] add_r, sub_r, inc_r, dec_r, neg_r;
   logic             add_c, sub_c;
   logic [WIDTH-1:0] and_r, or_r, xor_r, inv_r;
   logic [WIDTH-1:0] shl_r, shr_r;
   logic             shl_c, shr_c;
   logic             cmp_eq, cmp_gt;

   alu_arith #(.W(WIDTH)) u_arith (
      .a_i(tmp_q), .b_i(bus_i), .cin_i(flags_q.carry),
      .add_o(add_r), .add_c_o(add_c), .sub_o(sub_r), .sub_c_o(sub_c),
      .inc_o(inc_r), .dec_o(dec_r), .neg_o(neg_r)
   );

   alu_bitwise #(.W(WIDTH)) u_bitwise (
      .a_i(tmp_q), .b_i(bus_i),
      .and_o(and_r), .or_o(or_r), .xor_o(xor_r), .inv_o(inv_r)
   );

   alu_shift #(.W(WIDTH)) u_shift (
      .b_i(bus_i), .cin_i(flags_q.carry),
      .shl_o(shl_r), .shl_c_o(shl_c), .shr_o(shr_r), .shr_c_o(shr_c)
   );

   alu_compare #(.W(WIDTH), .FROM_SUB(CMP_FROM_SUB)) u_cmp (
      .a_i(tmp_q), .b_i(bus_i), .equal_o(cmp_eq), .above_o(cmp_gt)
   );

   logic [WIDTH-1:0] res;
   logic             c_own;
   logic             c_next;
   logic             is_cmp;

   always_comb begin
      res    = bus_i;
      c_own  = 1'b0;
      c_next = flags_q.carry;
      is_cmp = 1'b0;
      if (ext_zero) begin
         case (opc)
            OPC_ADD: begin res = add_r; c_own = 1'b1; c_next = add_c; end
            OPC_SUB: begin res = sub_r; c_own = 1'b1; c_next = sub_c; end
            OPC_INC: res = inc_r;
            OPC_DEC: res = dec_r;
            OPC_AND: res = and_r;
            OPC_OR:  res = or_r;
            OPC_XOR: res = xor_r;
            OPC_NOT: res = inv_r;
            OPC_SHL: begin res = shl_r; c_own = 1'b1; c_next = shl_c; end
            OPC_SHR: begin res = shr_r; c_own = 1'b1; c_next = shr_c; end
            OPC_NEG: res = neg_r;
            OPC_CMP: is_cmp = 1'b1;
            default: res = bus_i;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         tmp_q   <= '0;
         acc_q   <= '0;
         flags_q <= '0;
      end else begin
         if (hold_we_i) tmp_q <= bus_i;
         if (res_we_i && !is_cmp) acc_q <= res;
         if (flag_we_i) begin
            if (c_own) flags_q.carry <= c_next;
            if (is_cmp) begin
               flags_q.equal <= cmp_eq;
               flags_q.above <= cmp_gt;
            end
         end
      end
   end

   assign acc_o   = acc_q;
   assign carry_o = flags_q.carry;
   assign equal_o = flags_q.equal;
   assign above_o = flags_q.above;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int W    = 8,
   parameter int OP_W = 4
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic [W-1:0]  bus_i,
   input logic [OP_W-1:0] op_i,
   input logic          hold_we_i,
   input logic          res_we_i,
   input logic          flag_we_i,
   input logic [W-1:0]  tmp_q,
   input logic [W-1:0]  acc_o,
   input logic          carry_o,
   input logic          equal_o,
   input logic          above_o
);
   // R2
   tmp_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_we_i |=> tmp_q == $past(bus_i));

   // R2
   tmp_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !hold_we_i |=> $stable(tmp_q));

   // R3
   add_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == OP_W'(0) && res_we_i && flag_we_i) |=>
      {carry_o, acc_o} == ({1'b0, $past(tmp_q)} + {1'b0, $past(bus_i)} + {{W{1'b0}}, $past(carry_o)}));

   // R7
   shl_chain_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == OP_W'(8) && res_we_i && flag_we_i) |=>
      (acc_o == {$past(bus_i[W-2:0]), $past(carry_o)} && carry_o == $past(bus_i[W-1])));

   // R8
   cmp_acc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i == OP_W'(11)) |=> ($stable(acc_o) && $stable(carry_o)));

   // R9
   cmp_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i != OP_W'(11) || !flag_we_i) |=> ($stable(equal_o) && $stable(above_o)));

   // R9
   cmp_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !(equal_o && above_o));

   // R11
   acc_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !res_we_i |=> $stable(acc_o));

   // R11
   flag_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !flag_we_i |=> $stable(carry_o));
endmodule

bind acc_alu acc_alu_chk #(.W(WIDTH), .OP_W(OP_W)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .bus_i(bus_i), .op_i(op_i),
   .hold_we_i(hold_we_i), .res_we_i(res_we_i), .flag_we_i(flag_we_i),
   .tmp_q(tmp_q), .acc_o(acc_o), .carry_o(carry_o),
   .equal_o(equal_o), .above_o(above_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] bus;
   logic [3:0]   op;
   logic         hold_we, res_we, flag_we;
   logic [W-1:0] acc;
   logic         carry, equal, above;

   always #4 clk = ~clk;

   acc_alu dut (
      .clk_i(clk), .rst_i(rst), .bus_i(bus), .op_i(op),
      .hold_we_i(hold_we), .res_we_i(res_we), .flag_we_i(flag_we),
      .acc_o(acc), .carry_o(carry), .equal_o(equal), .above_o(above)
   );

   typedef struct {
      logic [W-1:0] acc;
      logic         c;
      logic         eq;
      logic         gt;
      string        tag;
   } exp_t;

   exp_t sb[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   logic [W-1:0] m_tmp, m_acc;
   logic         m_c, m_eq, m_gt;

   task automatic check(string tag, logic [W+2:0] got, logic [W+2:0] want);
      n_chk++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: got acc/c/eq/gt=%h expected %h", tag, got, want);
      end
   endtask

   // driver: applies one step and pushes what the requirements predict
   task automatic step(input logic [3:0] o, input logic [W-1:0] b,
                       input logic t, input logic a, input logic f, input string tag);
      logic [W:0]   s;
      logic [W-1:0] r;
      logic         nc;
      logic         cmp;
      exp_t         e;
      @(negedge clk);
      bus = b; op = o; hold_we = t; res_we = a; flag_we = f;
      r = b; nc = m_c; cmp = 1'b0;
      case (o)
         4'd0:  begin s = {1'b0, m_tmp} + {1'b0, b} + {{W{1'b0}}, m_c}; r = s[W-1:0]; nc = s[W]; end
         4'd1:  begin s = {1'b0, m_tmp} + {1'b0, ~b} + 9'd1; r = s[W-1:0]; nc = s[W]; end
         4'd2:  r = b + 8'd1;
         4'd3:  r = b - 8'd1;
         4'd4:  r = m_tmp & b;
         4'd5:  r = m_tmp | b;
         4'd6:  r = m_tmp ^ b;
         4'd7:  r = ~b;
         4'd8:  begin r = {b[W-2:0], m_c}; nc = b[W-1]; end
         4'd9:  begin r = {m_c, b[W-1:1]}; nc = b[0]; end
         4'd10: r = 8'd0 - b;
         4'd11: cmp = 1'b1;
         default: r = b;
      endcase
      if (a && !cmp) m_acc = r;
      if (f) begin
         m_c = nc;
         if (cmp) begin m_eq = (m_tmp == b); m_gt = (m_tmp > b); end
      end
      if (t) m_tmp = b;
      e.acc = m_acc; e.c = m_c; e.eq = m_eq; e.gt = m_gt; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic load(input logic [W-1:0] b);
      step(4'd12, b, 1'b1, 1'b0, 1'b0, "R2 load");
   endtask

   // monitor: pops one expectation per cycle, sampled after the edge settles
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, {acc, carry, equal, above}, {e.acc, e.c, e.eq, e.gt});
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; bus = '0; op = 4'd12; hold_we = 1'b1; res_we = 1'b1; flag_we = 1'b1;
      m_tmp = '0; m_acc = '0; m_c = 1'b0; m_eq = 1'b0; m_gt = 1'b0;
      bus = 8'hA5;
      repeat (3) @(negedge clk);
      rst = 1'b0; hold_we = 1'b0; res_we = 1'b0; flag_we = 1'b0;
      #1;
      // R1 reset state
      check("R1 reset", {acc, carry, equal, above}, 11'd0);

      // R3 add, carry out and carry in chained
      load(8'h3C);
      step(4'd0, 8'h05, 1'b0, 1'b1, 1'b1, "R3 add no carry");
      load(8'hF0);
      step(4'd0, 8'h20, 1'b0, 1'b1, 1'b1, "R3 add carry out");
      step(4'd0, 8'h0F, 1'b0, 1'b1, 1'b1, "R3 add carry-in wraps");
      step(4'd0, 8'h01, 1'b0, 1'b1, 1'b1, "R3 add uses carry");
      // R2 same-cycle load uses old TMP
      step(4'd0, 8'h11, 1'b1, 1'b1, 1'b1, "R2 load with add");
      step(4'd5, 8'h00, 1'b0, 1'b1, 1'b0, "R2 new TMP visible");

      // R4 subtract
      load(8'h50);
      step(4'd1, 8'h50, 1'b0, 1'b1, 1'b1, "R4 sub equal");
      step(4'd1, 8'h51, 1'b0, 1'b1, 1'b1, "R4 sub borrow");
      step(4'd1, 8'h10, 1'b0, 1'b1, 1'b1, "R4 sub no borrow");

      // R5 single-operand arithmetic, carry untouched
      step(4'd1, 8'h60, 1'b0, 1'b0, 1'b1, "R11 flags only");
      step(4'd2, 8'hFF, 1'b0, 1'b1, 1'b1, "R5 inc wrap");
      step(4'd3, 8'h00, 1'b0, 1'b1, 1'b1, "R5 dec wrap");
      step(4'd10, 8'h01, 1'b0, 1'b1, 1'b1, "R5 neg one");
      step(4'd10, 8'h80, 1'b0, 1'b1, 1'b1, "R5 neg min");
      step(4'd10, 8'h00, 1'b0, 1'b1, 1'b1, "R5 neg zero");

      // R6 logic
      load(8'hCA);
      step(4'd4, 8'h0F, 1'b0, 1'b1, 1'b1, "R6 and");
      step(4'd5, 8'h30, 1'b0, 1'b1, 1'b1, "R6 or");
      step(4'd6, 8'hFF, 1'b0, 1'b1, 1'b1, "R6 xor");
      step(4'd7, 8'h5A, 1'b0, 1'b1, 1'b1, "R6 not");

      // R7 shift chain through carry
      step(4'd8, 8'h81, 1'b0, 1'b1, 1'b1, "R7 shl");
      step(4'd8, m_acc, 1'b0, 1'b1, 1'b1, "R7 shl chained");
      step(4'd9, 8'h03, 1'b0, 1'b1, 1'b1, "R7 shr");
      step(4'd9, m_acc, 1'b0, 1'b1, 1'b1, "R7 shr chained");
      step(4'd9, 8'h02, 1'b0, 1'b1, 1'b1, "R7 shr carry out 0");

      // R8 and R9 compare in all orderings, ACC held
      load(8'h40);
      step(4'd11, 8'h40, 1'b0, 1'b1, 1'b1, "R8 cmp equal");
      step(4'd11, 8'h3F, 1'b0, 1'b1, 1'b1, "R8 cmp tmp larger");
      step(4'd11, 8'hC0, 1'b0, 1'b1, 1'b1, "R8 cmp bus larger unsigned");
      step(4'd11, 8'h40, 1'b0, 1'b1, 1'b0, "R9 cmp without flag strobe");
      step(4'd0, 8'h00, 1'b0, 1'b1, 1'b1, "R9 add leaves cmp flags");

      // R10 pass-through codes
      step(4'd12, 8'h77, 1'b0, 1'b1, 1'b1, "R10 pass 12");
      step(4'd15, 8'h9E, 1'b0, 1'b1, 1'b1, "R10 pass 15");

      // R11 strobes off
      step(4'd0, 8'hFF, 1'b0, 1'b0, 1'b0, "R11 no strobes");
      step(4'd8, 8'hFF, 1'b0, 1'b1, 1'b0, "R11 result only");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule